// File: doc/BRIEF.md
# Banked Byte Register Window

A byte-wide register file for a display transmitter. A host port carries an 8-bit address, 8-bit write data, a write strobe and a read strobe, and would typically sit behind a serial slave back end. Addresses below 0x30 form a shared region that decodes the same way at all times. Addresses 0x30 to 0xFF form an upper window. That window maps to one of two banks, chosen by a bank-select bit that lives in the shared region.

The bank selection is a two-state machine. In state `BANK_LO`, the upper window reaches bank 0, which holds the transmitter control register. In state `BANK_HI`, the upper window reaches bank 1, which holds fourteen packet data bytes. The machine has two transitions. `LO_TO_HI` is taken on a write to the select register with data bit 0 set. `HI_TO_LO` is taken on a write to the select register with data bit 0 clear. Any other access keeps the current state.

The shared region also holds a read-only status byte, sampled live from the hot-plug and video-stable inputs, and a register of five independent reset bits, each driving its own output. The control register drives an AV-mute output and a 3-bit colour-depth output. The packet bytes are brought out on a flat bus.

Top module: `banked_regwin`

## Requirements
- R1: After reset, every writable register is 0x00. The bank state is `BANK_LO`, so reads of 0x30 to 0xFF see bank 0. All control outputs are 0.
- R2: Addresses 0x00 to 0x2F read and write identically in both bank states. In particular, address 0x04 returns the same value from either bank.
- R3: Address 0x0F is the bank select. Only bit 0 is stored, and a read returns {7'b0, bit0}. A value of 1 means bank 1.
- R4: The control register at 0xC1 is reachable only in bank 0. In bank 1, address 0xC1 reads 0x00 and ignores writes.
- R5: In bank 1, addresses 0x58 to 0x65 (logical 0x158 to 0x165) are fourteen 8-bit packet bytes. Byte i sits at 0x58+i and drives pkt_bytes[8*i+7:8*i]. In bank 0 these addresses are unimplemented.
- R6: Address 0x0E is read-only. Bit 6 equals hpd_in and bit 4 equals vid_stable_in at the sampling edge. All other bits read 0, and writes have no effect.
- R7: Address 0x04 holds five reset bits. Bit 5 drives rst_ref, bit 4 drives rst_aclk, bit 3 drives rst_vid, bit 2 drives rst_aud and bit 0 drives rst_hdcp. Bits 7, 6 and 1 read 0.
- R8: At 0xC1, bit 0 drives av_mute and bits 6:4 drive color_depth, where the value 4 means 24-bit colour. Bits 7 and 3:1 read 0.
- R9: Writes to unimplemented addresses are ignored, and reads from them return 0x00.
- R10: A write to 0x0F changes the bank seen by the access in the very next cycle.
- R11: rdata updates at the clock edge where rd_en is high, with the register state from before any write in that same cycle. It holds its value while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| hpd_in | input | 1 | Hot-plug detect status input |
| vid_stable_in | input | 1 | Transmit-video-stable status input |
| rst_ref | output | 1 | Reference-domain reset |
| rst_aclk | output | 1 | Audio-clock-domain reset |
| rst_vid | output | 1 | Video reset |
| rst_aud | output | 1 | Audio reset |
| rst_hdcp | output | 1 | Content-protection reset |
| av_mute | output | 1 | AV-mute control |
| color_depth | output | 3 | Colour-depth code |
| pkt_bytes | output | 112 | Fourteen packet bytes, byte 0 in the low bits |

## Verification
A wrong bank state shows up on the first upper-window read after the faulty select write. The read returns 0x00 where a control or packet value was expected, or a value where 0x00 was expected. Because every address in both banks is swept, one read cycle exposes it. A broken decode or mask shows up in the rdata of the next cycle, or on the control and packet outputs right after the write edge. Stale status shows up on the first read of 0x0E after an input change.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
    typedef enum logic {
        BANK_LO,
        BANK_HI
    } bank_state_e;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_SWRST,
        TGT_STATUS,
        TGT_BANKSEL,
        TGT_CTRL,
        TGT_PKT
    } tgt_e;

    localparam int HPD_BIT      = 6;
    localparam int VSTB_BIT     = 4;
    localparam int RST_REF_BIT  = 5;
    localparam int RST_ACLK_BIT = 4;
    localparam int RST_VID_BIT  = 3;
    localparam int RST_AUD_BIT  = 2;
    localparam int RST_HDCP_BIT = 0;
    localparam int MUTE_BIT     = 0;
    localparam int DEPTH_LSB    = 4;
    localparam int DEPTH_W      = 3;
    localparam logic [7:0] SWRST_MASK = 8'h3D;
    localparam logic [7:0] CTRL_MASK  = 8'h71;
endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
    import regwin_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int COMMON_TOP  = 'h30,
    parameter int ADDR_SWRST  = 'h04,
    parameter int ADDR_STATUS = 'h0E,
    parameter int ADDR_BANK   = 'h0F,
    parameter int ADDR_CTRL   = 'hC1,
    parameter int PKT_BASE    = 'h58,
    parameter int PKT_LEN     = 14
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              bank_hi,
    output tgt_e              tgt,
    output logic [ADDR_W-1:0] off
);
    localparam int PKT_END = PKT_BASE + PKT_LEN;

    always_comb begin
        tgt = TGT_NONE;
        if (int'(addr) < COMMON_TOP) begin
            if (int'(addr) == ADDR_SWRST)       tgt = TGT_SWRST;
            else if (int'(addr) == ADDR_STATUS) tgt = TGT_STATUS;
            else if (int'(addr) == ADDR_BANK)   tgt = TGT_BANKSEL;
        end else if (!bank_hi) begin
            if (int'(addr) == ADDR_CTRL) tgt = TGT_CTRL;
        end else begin
            if (int'(addr) >= PKT_BASE && int'(addr) < PKT_END) tgt = TGT_PKT;
        end
    end

    assign off = addr - ADDR_W'(PKT_BASE);
endmodule

// File: rtl/regwin_bank_fsm.sv
module regwin_bank_fsm
    import regwin_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_wr,
    input  logic sel_bit,
    output logic bank_hi
);
    bank_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BANK_LO;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BANK_LO: if (sel_wr && sel_bit)  state_d = BANK_HI;  // LO_TO_HI
            BANK_HI: if (sel_wr && !sel_bit) state_d = BANK_LO;  // HI_TO_LO
        endcase
    end

    always_comb begin
        unique case (state_q)
            BANK_LO: bank_hi = 1'b0;
            BANK_HI: bank_hi = 1'b1;
        endcase
    end
endmodule

// File: rtl/regwin_pkt_store.sv
module regwin_pkt_store #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter int PKT_LEN = 14
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [ADDR_W-1:0]         off,
    input  logic [DATA_W-1:0]         wdata,
    output logic [DATA_W-1:0]         rd_byte,
    output logic [PKT_LEN*DATA_W-1:0] flat
);
    logic [DATA_W-1:0] mem [PKT_LEN];

    for (genvar i = 0; i < PKT_LEN; i++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         mem[i] <= '0;
            else if (we && off == ADDR_W'(i))   mem[i] <= wdata;
        end
        assign flat[i*DATA_W +: DATA_W] = mem[i];
    end

    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < PKT_LEN; i++)
            if (off == ADDR_W'(i)) rd_byte = mem[i];
    end
endmodule

// File: rtl/banked_regwin.sv
module banked_regwin
    import regwin_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter int PKT_LEN = 14
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         wdata,
    output logic [DATA_W-1:0]         rdata,
    input  logic                      hpd_in,
    input  logic                      vid_stable_in,
    output logic                      rst_ref,
    output logic                      rst_aclk,
    output logic                      rst_vid,
    output logic                      rst_aud,
    output logic                      rst_hdcp,
    output logic                      av_mute,
    output logic [DEPTH_W-1:0]        color_depth,
    output logic [PKT_LEN*DATA_W-1:0] pkt_bytes
);
    localparam logic [DATA_W-1:0] SWRST_M = DATA_W'(SWRST_MASK);
    localparam logic [DATA_W-1:0] CTRL_M  = DATA_W'(CTRL_MASK);

    tgt_e              tgt;
    logic [ADDR_W-1:0] off;
    logic              bank_hi;
    logic [DATA_W-1:0] swrst_q, ctrl_q, status_b, pkt_rd, rd_mux;

    regwin_decode #(.ADDR_W(ADDR_W), .PKT_LEN(PKT_LEN)) u_dec (
        .addr(addr), .bank_hi(bank_hi), .tgt(tgt), .off(off)
    );

    regwin_bank_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .sel_wr(wr_en && tgt == TGT_BANKSEL),
        .sel_bit(wdata[0]),
        .bank_hi(bank_hi)
    );

    regwin_pkt_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PKT_LEN(PKT_LEN)) u_pkt (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en && tgt == TGT_PKT),
        .off(off), .wdata(wdata),
        .rd_byte(pkt_rd), .flat(pkt_bytes)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            swrst_q <= '0;
            ctrl_q  <= '0;
        end else if (wr_en) begin
            if (tgt == TGT_SWRST) swrst_q <= wdata & SWRST_M;
            if (tgt == TGT_CTRL)  ctrl_q  <= wdata & CTRL_M;
        end
    end

    always_comb begin
        status_b           = '0;
        status_b[HPD_BIT]  = hpd_in;
        status_b[VSTB_BIT] = vid_stable_in;
    end

    always_comb begin
        case (tgt)
            TGT_SWRST:   rd_mux = swrst_q;
            TGT_STATUS:  rd_mux = status_b;
            TGT_BANKSEL: rd_mux = DATA_W'(bank_hi);
            TGT_CTRL:    rd_mux = ctrl_q;
            TGT_PKT:     rd_mux = pkt_rd;
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    assign rst_ref     = swrst_q[RST_REF_BIT];
    assign rst_aclk    = swrst_q[RST_ACLK_BIT];
    assign rst_vid     = swrst_q[RST_VID_BIT];
    assign rst_aud     = swrst_q[RST_AUD_BIT];
    assign rst_hdcp    = swrst_q[RST_HDCP_BIT];
    assign av_mute     = ctrl_q[MUTE_BIT];
    assign color_depth = ctrl_q[DEPTH_LSB +: DEPTH_W];
endmodule

// File: rtl/regwin_chk.sv
module regwin_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] addr,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       hpd_in,
    input logic       vid_stable_in,
    input logic       bank_hi,
    input logic       av_mute,
    input logic [2:0] color_depth,
    input logic [4:0] rst_vec
);
    // R6
    status_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && addr == 8'h0E |=>
        rdata == {1'b0, $past(hpd_in), 1'b0, $past(vid_stable_in), 4'b0000});

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // R10
    bank_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == 8'h0F |=> bank_hi == $past(wdata[0]));

    // R9
    unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && addr < 8'h30 && addr != 8'h04 && addr != 8'h0E && addr != 8'h0F
        |=> rdata == 8'h00);

    // R4
    ctrl_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == 8'hC1 && !bank_hi) |=> $stable(av_mute) && $stable(color_depth));

    // R7
    rst_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == 8'h04) |=> $stable(rst_vec));
endmodule

bind banked_regwin regwin_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .hpd_in(hpd_in), .vid_stable_in(vid_stable_in), .bank_hi(bank_hi),
    .av_mute(av_mute), .color_depth(color_depth),
    .rst_vec({rst_ref, rst_aclk, rst_vid, rst_aud, rst_hdcp})
);

// File: tb/banked_regwin_test.sv
module banked_regwin_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]   addr = '0, wdata = '0;
    logic [7:0]   rdata;
    logic         hpd_in = 1'b0, vid_stable_in = 1'b0;
    logic         rst_ref, rst_aclk, rst_vid, rst_aud, rst_hdcp, av_mute;
    logic [2:0]   color_depth;
    logic [111:0] pkt_bytes;

    int  n_chk = 0, n_bad = 0;
    bit  done = 0;

    logic [7:0] m_rst = '0, m_ctrl = '0;
    logic       m_bank = 1'b0;
    logic [7:0] m_pkt [14];

    always #10 clk = ~clk;

    banked_regwin uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .hpd_in(hpd_in), .vid_stable_in(vid_stable_in),
        .rst_ref(rst_ref), .rst_aclk(rst_aclk), .rst_vid(rst_vid), .rst_aud(rst_aud),
        .rst_hdcp(rst_hdcp), .av_mute(av_mute), .color_depth(color_depth),
        .pkt_bytes(pkt_bytes)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(logic bnk, int a);
        if (a == 'h04) return m_rst;
        if (a == 'h0E) return {1'b0, hpd_in, 1'b0, vid_stable_in, 4'b0};
        if (a == 'h0F) return {7'b0, m_bank};
        if (a < 'h30)  return 8'h00;
        if (!bnk)      return (a == 'hC1) ? m_ctrl : 8'h00;
        if (a >= 'h58 && a <= 'h65) return m_pkt[a - 'h58];
        return 8'h00;
    endfunction

    function automatic string tag(logic bnk, int a);
        if (a == 'h04) return bnk ? "R2" : "R7";
        if (a == 'h0E) return "R6";
        if (a == 'h0F) return "R3";
        if (a == 'hC1) return "R4";
        if (bnk && a >= 'h58 && a <= 'h65) return "R5";
        return "R9";
    endfunction

    task automatic do_wr(int a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = 8'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 'h04) m_rst = d & 8'h3D;
        if (a == 'h0F) m_bank = d[0];
        if (a == 'hC1 && !m_bank) m_ctrl = d & 8'h71;
        if (m_bank && a >= 'h58 && a <= 'h65) m_pkt[a - 'h58] = d;
    endtask

    task automatic do_rd(int a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = 8'(a);
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic sweep_read();
        logic [7:0] v;
        for (int a = 0; a < 256; a++) begin
            do_rd(a, v);
            chk(tag(m_bank, a), v, exp_rd(m_bank, a));
        end
    endtask

    task automatic sweep_write(logic [7:0] key);
        for (int a = 0; a < 256; a++)
            if (a != 'h0F) do_wr(a, 8'(a) ^ key);
    endtask

    task automatic chk_outputs(string req);
        chk(req, {rst_ref, rst_aclk, rst_vid, rst_aud, rst_hdcp},
            {3'b0, m_rst[5], m_rst[4], m_rst[3], m_rst[2], m_rst[0]});
        chk(req, {4'b0, color_depth, av_mute}, {4'b0, m_ctrl[6:4], m_ctrl[0]});
        for (int i = 0; i < 14; i++) chk(req, pkt_bytes[i*8 +: 8], m_pkt[i]);
    endtask

    initial begin
        for (int i = 0; i < 14; i++) m_pkt[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        begin
            logic [7:0] v;
            // R1: reset state at the ports and across the bank 0 map
            chk("R1", rdata, 8'h00);
            chk_outputs("R1");
            sweep_read();
            // R6: all four status input combinations
            for (int k = 0; k < 4; k++) begin
                hpd_in = k[1]; vid_stable_in = k[0];
                do_rd('h0E, v);
                chk("R6", v, {1'b0, k[1], 1'b0, k[0], 4'b0});
            end
            hpd_in = 1'b1; vid_stable_in = 1'b0;
            // bank 0 write sweep, then the same in bank 1
            sweep_write(8'hA5);
            chk_outputs("R7");
            sweep_read();
            do_wr('h0F, 8'hFF);
            do_rd('h0F, v);
            chk("R3", v, 8'h01);
            sweep_write(8'h3C);
            chk_outputs("R5");
            sweep_read();
            do_wr('h0F, 8'h00);
            sweep_read();
            // R8: 24-bit depth code with mute set
            do_wr('hC1, 8'hC1);
            chk("R8", {5'b0, color_depth}, 8'h04);
            chk("R8", {7'b0, av_mute}, 8'h01);
            // R10: select write followed by an access in the next cycle
            @(negedge clk);
            wr_en = 1'b1; addr = 8'h0F; wdata = 8'h01;
            @(negedge clk);
            wr_en = 1'b0; m_bank = 1'b1;
            rd_en = 1'b1; addr = 8'h5A;
            @(negedge clk);
            rd_en = 1'b0;
            chk("R10", rdata, m_pkt[2]);
            // R11: rdata holds while rd_en is low
            repeat (5) @(negedge clk);
            chk("R11", rdata, m_pkt[2]);
            // R11: same-cycle write and read returns the old value
            @(negedge clk);
            wr_en = 1'b1; rd_en = 1'b1; addr = 8'h04; wdata = 8'hFF;
            @(negedge clk);
            wr_en = 1'b0; rd_en = 1'b0;
            chk("R11", rdata, m_rst);
            m_rst = 8'h3D;
            chk_outputs("R7");
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule